// File: doc/BRIEF.md
# Fault Count and Latch-Off Supervisor

This block sits beside a boost LED backlight controller and decides when a fault is bad enough to shut the controller down for good. Three digital fault flags arrive from external comparators: output over-voltage, LED over-current and LED string open. Each flag is first brought into the switching-oscillator clock domain through a two-flop synchronizer. Each fault class then has its own persistence counter, which counts oscillator clocks while the fault is present. The counter drops back to zero as soon as the fault goes away before the limit.

Over-voltage is handled specially. While it is present, the switch-drive enable and the dimming enable are forced off at once. If it clears within a short grace period of four clocks, switching restarts on its own. The other two faults do not gate the outputs. They only latch the controller off after a long persistence of 2^17 clocks. The open-string check counts only once soft start has finished.

When any counter reaches its limit, the supervisor latches off. Both enables are then held low and the active-low fail flag is pulled down. The latch is released only by the global reset-release input going low, which is the standby or undervoltage reset cycle. The PWM dimming input never clears a counter or the latch.

Top module: `fault_latch_supervisor`

## Requirements
- R1: While `rst_n` is low and just after it returns high, `latched` is 0 and `fail_n` is 1. With no fault present, `gate_en` is 1 and `dim_en` equals `pwm_in`.
- R2: Every fault flag passes through a two-flop synchronizer. A change on `ov_flag` made between edges reaches `gate_en` at the second rising clock edge, not at the first.
- R3: While the synchronized over-voltage flag is 1, `gate_en` and `dim_en` are both 0. If the flag clears before the latch limit, `gate_en` returns to 1 without any reset (auto-restart).
- R4: Over-voltage latches the block when it is seen on OV_LIMIT (default 4) consecutive synchronized clocks. With one clock fewer, the block does not latch.
- R5: Over-voltage counting does not depend on `pwm_in`. An over-voltage that persists while `pwm_in` is 0 still latches.
- R6: LED over-current latches the block when it is seen on 2^LONG_W (default 2^17) consecutive synchronized clocks. With one clock fewer, the block does not latch.
- R7: The open-string fault is counted only while `ss_done` is 1. With `ss_done` at 0 it never latches. With `ss_done` at 1 it latches after 2^LONG_W clocks.
- R8: `pwm_in` at 0, or toggling, does not reset a fault counter while the fault persists.
- R9: A counter returns to zero whenever its fault deasserts before the limit. Two bursts that are each one clock short of the limit, separated by a gap, do not latch.
- R10: Once latched, the block stays latched with all fault flags clear. During that time `gate_en` and `dim_en` are 0 and `fail_n` is 0. Only `rst_n` low clears the latch.
- R11: When the block is neither latched nor in over-voltage, `dim_en` follows `pwm_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switching-oscillator clock; all counting is in this domain |
| rst_n | input | 1 | Global reset-release (standby/undervoltage), active low, asynchronous |
| ov_flag | input | 1 | Output over-voltage comparator flag, asynchronous |
| ocp_flag | input | 1 | LED over-current comparator flag, asynchronous |
| open_flag | input | 1 | LED string open comparator flag, asynchronous |
| ss_done | input | 1 | Soft start finished; enables open-string counting |
| pwm_in | input | 1 | PWM dimming input |
| gate_en | output | 1 | Switch-drive enable |
| dim_en | output | 1 | Dimming-output enable |
| latched | output | 1 | Controller latched off |
| fail_n | output | 1 | Fail flag, active low; high means released |

## Verification
A counter that fails to clear between bursts shows up at the ports as a premature `latched` on the second partial burst, at the edge where the running sum reaches the limit. A counter that clears on PWM shows up as a missing latch at the expected edge. A latch that does not stick shows `gate_en` back at 1 within one clock of the fault flag clearing. A wrong synchronizer depth moves the `gate_en` drop by a whole cycle at the over-voltage onset. A wrong depth also shifts every latch edge, so the bench checks each one-short and exact-limit pair on the cycle it occurs.

// File: rtl/fls_pkg.sv
package fls_pkg;

  localparam int NUM_FAULTS = 3;

  typedef enum int {
    FLT_OV   = 0,
    FLT_OCP  = 1,
    FLT_OPEN = 2
  } fault_idx_e;

  // Persistence limit, in oscillator clocks, for one fault class.
  function automatic int fault_limit(input int idx, input int ov_limit, input int long_w);
    if (idx == FLT_OV) return ov_limit;
    return 1 << long_w;
  endfunction

  // Counter width able to hold 0 .. limit.
  function automatic int count_bits(input int limit);
    if (limit < 2) return 1;
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/fls_sync.sv
module fls_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fls_timer.sv
module fls_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic hit
);
  import fls_pkg::*;
  localparam int CW = count_bits(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit = active && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (!hit)    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/fls_latch.sv
module fls_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hits,
  output logic         latched
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latched <= 1'b0;
    else if (|hits) latched <= 1'b1;
  end
endmodule

// File: rtl/fault_latch_supervisor.sv
module fault_latch_supervisor #(
  parameter int OV_LIMIT    = 4,
  parameter int LONG_W      = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_flag,
  input  logic ocp_flag,
  input  logic open_flag,
  input  logic ss_done,
  input  logic pwm_in,
  output logic gate_en,
  output logic dim_en,
  output logic latched,
  output logic fail_n
);
  import fls_pkg::*;

  logic [NUM_FAULTS-1:0] flt_raw;
  logic [NUM_FAULTS-1:0] flt_sync;
  logic [NUM_FAULTS-1:0] flt_active;
  logic [NUM_FAULTS-1:0] flt_hit;
  logic                  any_hit;
  logic                  ov_now;

  assign flt_raw[FLT_OV]   = ov_flag;
  assign flt_raw[FLT_OCP]  = ocp_flag;
  assign flt_raw[FLT_OPEN] = open_flag;

  fls_sync #(.WIDTH(NUM_FAULTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (flt_raw),
    .q     (flt_sync)
  );

  assign flt_active[FLT_OV]   = flt_sync[FLT_OV];
  assign flt_active[FLT_OCP]  = flt_sync[FLT_OCP];
  assign flt_active[FLT_OPEN] = flt_sync[FLT_OPEN] & ss_done;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_timer
    localparam int LIM = fault_limit(g, OV_LIMIT, LONG_W);
    fls_timer #(.LIMIT(LIM)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (flt_active[g]),
      .hit    (flt_hit[g])
    );
  end

  assign any_hit = |flt_hit;

  fls_latch #(.N(NUM_FAULTS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hits    (flt_hit),
    .latched (latched)
  );

  assign ov_now  = flt_sync[FLT_OV];
  assign gate_en = !latched && !ov_now;
  assign dim_en  = gate_en && pwm_in;
  assign fail_n  = !latched;
endmodule

// File: rtl/fls_checker.sv
module fls_checker (
  input logic clk,
  input logic rst_n,
  input logic pwm_in,
  input logic gate_en,
  input logic dim_en,
  input logic latched,
  input logic ov_sync,
  input logic any_hit
);
  a_r3_ov_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ov_sync |-> (!gate_en && !dim_en));

  a_r10_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> latched);

  a_r10_latched_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> (!gate_en && !dim_en));

  a_r4_latch_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched) |-> $past(any_hit));

  a_r11_dim_needs_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |-> !dim_en);
endmodule

bind fault_latch_supervisor fls_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_in  (pwm_in),
  .gate_en (gate_en),
  .dim_en  (dim_en),
  .latched (latched),
  .ov_sync (ov_now),
  .any_hit (any_hit)
);

// File: tb/tb_fault_latch_supervisor.sv
`timescale 1ns/1ps
module tb_fault_latch_supervisor;
  localparam int OVL = 4;
  localparam int LW  = 7;
  localparam int LL  = 1 << LW;

  logic clk = 0;
  logic rst_n = 0;
  logic ov_flag = 0, ocp_flag = 0, open_flag = 0, ss_done = 0, pwm_in = 0;
  logic gate_en, dim_en, latched, fail_n;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  fault_latch_supervisor #(.OV_LIMIT(OVL), .LONG_W(LW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .ov_flag(ov_flag), .ocp_flag(ocp_flag),
    .open_flag(open_flag), .ss_done(ss_done), .pwm_in(pwm_in),
    .gate_en(gate_en), .dim_en(dim_en), .latched(latched), .fail_n(fail_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    ov_flag = 0; ocp_flag = 0; open_flag = 0;
    rst_n = 0; tick(2);
    rst_n = 1; tick(1);
  endtask

  task automatic t_reset();
    pwm_in = 1; rst_n = 0; tick(2);
    chk("R1 latched in reset", latched, 1'b0);
    chk("R1 fail_n in reset", fail_n, 1'b1);
    rst_n = 1; tick(1);
    chk("R1 gate_en idle", gate_en, 1'b1);
    chk("R1 dim_en idle pwm=1", dim_en, 1'b1);
    pwm_in = 0; tick(1);
    chk("R11 dim_en follows pwm=0", dim_en, 1'b0);
    pwm_in = 1; tick(1);
    chk("R11 dim_en follows pwm=1", dim_en, 1'b1);
  endtask

  task automatic t_ov_grace();
    pwm_in = 1;
    ov_flag = 1; tick(1);
    chk("R2 gate_en after first edge", gate_en, 1'b1);
    tick(1);
    chk("R2 gate_en off after second edge", gate_en, 1'b0);
    chk("R3 dim_en off during ov", dim_en, 1'b0);
    tick(OVL - 3);
    ov_flag = 0; tick(4);
    chk("R4 one short of ov limit no latch", latched, 1'b0);
    chk("R3 auto-restart gate_en", gate_en, 1'b1);
    chk("R3 auto-restart dim_en", dim_en, 1'b1);
  endtask

  task automatic t_ov_latch();
    pwm_in = 0;
    ov_flag = 1; tick(OVL + 1);
    chk("R4 not latched before limit edge", latched, 1'b0);
    tick(1);
    chk("R4 R5 latched at ov limit with pwm=0", latched, 1'b1);
    ov_flag = 0; tick(10);
    chk("R10 stays latched", latched, 1'b1);
    chk("R10 fail_n low", fail_n, 1'b0);
    chk("R10 gate_en off", gate_en, 1'b0);
    pwm_in = 1; tick(2);
    chk("R10 dim_en off with pwm=1", dim_en, 1'b0);
    pwm_in = 0; tick(2); pwm_in = 1; tick(2);
    chk("R10 pwm cycle does not clear", latched, 1'b1);
    do_reset();
    chk("R10 rst_n clears latch", latched, 1'b0);
    chk("R10 fail_n released", fail_n, 1'b1);
  endtask

  task automatic t_ocp();
    pwm_in = 1;
    ocp_flag = 1; tick(LL - 1); ocp_flag = 0; tick(4);
    chk("R6 ocp one short no latch", latched, 1'b0);
    chk("R6 ocp does not gate drive", gate_en, 1'b1);
    ocp_flag = 1; tick(LL + 1);
    chk("R6 ocp not latched before edge", latched, 1'b0);
    tick(1);
    chk("R6 ocp latched at limit", latched, 1'b1);
    do_reset();
  endtask

  task automatic t_open();
    ss_done = 0;
    open_flag = 1; tick(2 * LL); open_flag = 0; tick(4);
    chk("R7 open ignored before soft start", latched, 1'b0);
    ss_done = 1;
    open_flag = 1; tick(LL + 2);
    chk("R7 open latched after soft start", latched, 1'b1);
    do_reset();
  endtask

  task automatic t_pwm_no_reset();
    ss_done = 1;
    ocp_flag = 1;
    for (int i = 0; i < LL + 2; i++) begin
      pwm_in = ((i / 3) % 2) == 0;
      tick(1);
    end
    chk("R8 pwm toggling keeps ocp count", latched, 1'b1);
    do_reset();
    pwm_in = 0;
    open_flag = 1; tick(LL + 2);
    chk("R8 pwm low keeps open count", latched, 1'b1);
    do_reset();
  endtask

  task automatic t_partial();
    ss_done = 1; pwm_in = 1;
    open_flag = 1; tick(LL - 1); open_flag = 0; tick(4);
    open_flag = 1; tick(LL - 1); open_flag = 0; tick(4);
    chk("R9 open bursts do not sum", latched, 1'b0);
    ov_flag = 1; tick(OVL - 1); ov_flag = 0; tick(3);
    ov_flag = 1; tick(OVL - 1); ov_flag = 0; tick(4);
    chk("R9 ov bursts do not sum", latched, 1'b0);
    chk("R9 gate_en restored", gate_en, 1'b1);
  endtask

  initial begin
    t_reset();
    t_ov_grace();
    t_ov_latch();
    t_ocp();
    t_open();
    t_pwm_no_reset();
    t_partial();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule